// File: doc/BRIEF.md
# Bit-Slice Integer ALU

This block is the integer arithmetic and logic unit of a small RISC execution stage. It takes two operands and a four-bit operation code and produces, within the same cycle and with no storage, a result word and three flags: a zero flag used for branch-on-equal and branch-on-not-equal tests, the carry out of the most significant bit, and a signed overflow indication.

The datapath is a chain of identical one-bit slices. Every slice forms the AND, the OR and the full-adder sum of its operand bits at once, and a four-way selector in each slice picks what drives that result bit. One negate control both inverts operand b in every slice and supplies the carry into bit 0, so subtraction is a plus the inverted b plus one. Carries ripple from bit 0 upward. For set-less-than, the selector's fourth input takes a "less" value that is zero for every bit except bit 0, which receives the comparison outcome computed from the subtraction at the top of the chain.

A separate `unsigned_op` input chooses the unsigned form of an operation: it switches the comparison source for set-less-than and suppresses the overflow flag. Overflow only sets the flag; the block raises no trap.

Top module: `bitslice_alu`

## Requirements
- R1: The operation code is {invert_a, negate_b, sel[1:0]}; sel 00 selects the bitwise AND, 01 the bitwise OR, 10 the adder sum and 11 the less value. Code 0000 yields a AND b and code 0001 yields a OR b.
- R2: Code 0010 yields (a + b) modulo 2^32, and `carry_out` is the carry out of bit 31 of that sum.
- R3: Code 0110 yields (a - b) modulo 2^32, computed as a + NOT b + 1; `carry_out` is then 1 exactly when a is greater than or equal to b as unsigned numbers.
- R4: Code 1100 yields NOR of a and b (both operands inverted, then ANDed).
- R5: Code 0111 with `unsigned_op` = 0 yields 1 when a is less than b as signed two's complement numbers and 0 otherwise, including when a - b overflows (for example a = 0x80000000, b = 1 gives 1); bits 31 to 1 of the result are always 0.
- R6: Code 0111 with `unsigned_op` = 1 yields 1 when a is less than b as unsigned numbers and 0 otherwise; bits 31 to 1 of the result are 0.
- R7: `zero` is 1 exactly when all 32 result bits are 0; in particular code 0110 with a = b gives `zero` = 1.
- R8: With `unsigned_op` = 0, `overflow` is 1 for code 0010 exactly when both operands share a sign and the sum's sign differs (0x7FFFFFFF + 1 sets it), and for code 0110 exactly when the signs of a and b differ and the result's sign differs from a (0x80000000 - 1 sets it).
- R9: With `unsigned_op` = 1, `overflow` is 0 for every operation, while result and `carry_out` are unchanged.
- R10: All outputs are a pure function of the current inputs: no output depends on any earlier input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | input | 4 | Operation code {invert_a, negate_b, sel[1:0]} |
| unsigned_op | input | 1 | 1 selects unsigned comparison and masks overflow |
| result | output | 32 | Selected result word |
| zero | output | 1 | 1 when result is all zeros |
| carry_out | output | 1 | Carry out of bit 31 of the adder |
| overflow | output | 1 | Signed overflow of the adder, 0 when unsigned_op is 1 |

## Verification
Every output of this block is due in the same cycle as its stimulus, since no register lies between inputs and outputs. The bench therefore changes the operands and operation code shortly after a rising clock edge and compares all four outputs against its behavioural model at the following falling edge, one comparison per clock, so the ripple chain has settled and no earlier stimulus can leak into a later check. Directed vectors cover the overflow corners, equal operands and signed versus unsigned comparison of mixed-sign values, followed by a long pseudo-random sweep over all six operations in both forms.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    localparam logic [OP_W-1:0] OPC_AND = 4'b0000;
    localparam logic [OP_W-1:0] OPC_OR  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD = 4'b0010;
    localparam logic [OP_W-1:0] OPC_SUB = 4'b0110;
    localparam logic [OP_W-1:0] OPC_SLT = 4'b0111;
    localparam logic [OP_W-1:0] OPC_NOR = 4'b1100;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       inv_a,
    input  logic       neg_b,
    input  logic       c_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res_bit,
    output logic       sum_bit,
    output logic       c_out
);
    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff   = a_bit ^ inv_a;
        b_eff   = b_bit ^ neg_b;
        sum_bit = a_eff ^ b_eff ^ c_in;
        c_out   = (a_eff & b_eff) | (a_eff & c_in) | (b_eff & c_in);
        unique case (sel)
            SEL_AND:  res_bit = a_eff & b_eff;
            SEL_OR:   res_bit = a_eff | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_less_gen.sv
module alu_less_gen (
    input  logic top_sum,
    input  logic ovf_raw,
    input  logic top_carry,
    input  logic use_unsigned,
    output logic less_bit
);
    // Signed: sign of a-b corrected by overflow. Unsigned: borrow out.
    always_comb begin
        if (use_unsigned) less_bit = ~top_carry;
        else              less_bit = top_sum ^ ovf_raw;
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [OP_W-1:0]  alu_op,
    input  logic             unsigned_op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    logic             inv_a;
    logic             neg_b;
    slice_sel_e       sel;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sums;
    logic [WIDTH-1:0] less_vec;
    logic             less0;
    logic             ovf_raw;

    always_comb begin
        inv_a    = alu_op[3];
        neg_b    = alu_op[2];
        sel      = slice_sel_e'(alu_op[1:0]);
        carry[0] = neg_b;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign less_vec[i] = less0;
            end else begin : g_upper
                assign less_vec[i] = 1'b0;
            end
            alu_bit_slice u_slice (
                .a_bit   (opnd_a[i]),
                .b_bit   (opnd_b[i]),
                .inv_a   (inv_a),
                .neg_b   (neg_b),
                .c_in    (carry[i]),
                .less_in (less_vec[i]),
                .sel     (sel),
                .res_bit (result[i]),
                .sum_bit (sums[i]),
                .c_out   (carry[i+1])
            );
        end
    endgenerate

    assign ovf_raw = carry[MSB] ^ carry[WIDTH];

    alu_less_gen u_less (
        .top_sum      (sums[MSB]),
        .ovf_raw      (ovf_raw),
        .top_carry    (carry[WIDTH]),
        .use_unsigned (unsigned_op),
        .less_bit     (less0)
    );

    always_comb begin
        zero      = ~(|result);
        carry_out = carry[WIDTH];
        overflow  = ovf_raw & ~unsigned_op;
    end
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [OP_W-1:0]  alu_op,
    input logic             unsigned_op,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             carry_out,
    input logic             overflow
);
    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;

    always_comb begin
        add_ref = {1'b0, opnd_a} + {1'b0, opnd_b};
        sub_ref = {1'b0, opnd_a} - {1'b0, opnd_b};

        a_r7_zero: assert (zero == (result == '0))
            else $error("zero flag disagrees with result");

        if (alu_op == OPC_SLT) begin
            a_r5_slt_upper: assert (result[WIDTH-1:1] == '0)
                else $error("set-less-than upper bits not clear");
        end

        if (unsigned_op) begin
            a_r9_unsigned_no_ovf: assert (!overflow)
                else $error("overflow raised on unsigned operation");
        end

        if (alu_op == OPC_ADD) begin
            a_r2_add_sum: assert ({carry_out, result} == add_ref)
                else $error("add sum or carry wrong");
            if (!unsigned_op) begin
                a_r8_add_ovf: assert (overflow ==
                    ((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) && (result[WIDTH-1] != opnd_a[WIDTH-1])))
                    else $error("add overflow wrong");
            end
        end

        if (alu_op == OPC_SUB) begin
            a_r3_sub_diff: assert (result == sub_ref[WIDTH-1:0] && carry_out == (opnd_a >= opnd_b))
                else $error("subtract result or carry wrong");
        end
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .alu_op      (alu_op),
    .unsigned_op (unsigned_op),
    .result      (result),
    .zero        (zero),
    .carry_out   (carry_out),
    .overflow    (overflow)
);

// File: tb/bitslice_alu_tb_top.sv
`timescale 1ns/1ps
module bitslice_alu_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   op = 4'b0000;
    logic         uns = 1'b0;
    logic [W-1:0] result;
    logic         zero;
    logic         carry_out;
    logic         overflow;

    int total = 0;
    int bad   = 0;
    logic [31:0] rng = 32'h1234_5679;

    always #2.5 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .opnd_a      (a),
        .opnd_b      (b),
        .alu_op      (op),
        .unsigned_op (uns),
        .result      (result),
        .zero        (zero),
        .carry_out   (carry_out),
        .overflow    (overflow)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: a=%h b=%h op=%b uns=%0d got=%h exp=%h", req, what, a, b, op, uns, got, exp);
        end
    endtask

    // Behavioural reference; compares all outputs half a cycle after driving.
    task automatic run(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [3:0] top, input logic tuns, input string req);
        logic [W-1:0] av, bv, er;
        logic [W:0]   s;
        logic         ec, eo;
        @(posedge clk);
        #1;
        a = ta; b = tb; op = top; uns = tuns;
        av = top[3] ? ~ta : ta;
        bv = top[2] ? ~tb : tb;
        s  = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, top[2]};
        ec = s[W];
        eo = !tuns && (av[W-1] == bv[W-1]) && (s[W-1] != av[W-1]);
        case (top[1:0])
            2'b00: er = av & bv;
            2'b01: er = av | bv;
            2'b10: er = s[W-1:0];
            default: er = tuns ? {{(W-1){1'b0}}, (ta < tb)}
                               : {{(W-1){1'b0}}, ($signed(ta) < $signed(tb))};
        endcase
        @(negedge clk);
        check(req, "result", result, er);
        check("R7", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
        check(req, "carry_out", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, ec});
        check(tuns ? "R9" : "R8", "overflow", {{(W-1){1'b0}}, overflow}, {{(W-1){1'b0}}, eo});
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] ops [6];
        ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
        ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset-time inputs all zero give a zero AND result
        check("R10", "reset result", result, '0);
        check("R7", "reset zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

        run(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, 1'b0, "R1");
        run(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, 1'b0, "R1");
        run(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, 1'b0, "R8");
        run(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, 1'b0, "R2");
        run(32'h8000_0000, 32'h0000_0001, 4'b0110, 1'b0, "R8");
        run(32'h8000_0000, 32'h0000_0001, 4'b0110, 1'b1, "R9");
        run(32'h1357_9BDF, 32'h1357_9BDF, 4'b0110, 1'b0, "R3");
        run(32'h0000_0003, 32'h0000_0005, 4'b0110, 1'b0, "R3");
        run(32'hA5A5_0000, 32'h0000_5A5A, 4'b1100, 1'b0, "R4");
        run(32'h8000_0000, 32'h0000_0001, 4'b0111, 1'b0, "R5");
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111, 1'b0, "R5");
        run(32'h8000_0000, 32'h0000_0001, 4'b0111, 1'b1, "R6");
        run(32'h0000_0001, 32'hFFFF_FFFF, 4'b0111, 1'b1, "R6");
        run(32'h0000_0042, 32'h0000_0042, 4'b0111, 1'b0, "R5");
        run(32'h0000_0042, 32'h0000_0042, 4'b0111, 1'b1, "R6");
        run(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, 1'b1, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb;
            logic [3:0]   rop;
            logic         ru;
            string        rq;
            rng = next_rng(rng); ra = rng;
            rng = next_rng(rng); rb = (rng[3:0] == 4'd0) ? ra : rng;
            rng = next_rng(rng);
            rop = ops[rng[7:0] % 6];
            ru  = rng[9];
            case (rop)
                4'b0000, 4'b0001: rq = "R1";
                4'b0010: rq = "R2";
                4'b0110: rq = "R3";
                4'b1100: rq = "R4";
                default: rq = ru ? "R6" : "R5";
            endcase
            run(ra, rb, rop, ru, rq);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule